// File: doc/BRIEF.md
# Cascadable Sequential Configuration Memory Reader

This block is the read side of a memory that streams a stored configuration image into a device being configured. The image sits in an internal byte array, which a simple write port fills before reading begins. Once the chip is selected and its output enable is active, every rising clock edge steps an internal read pointer through the image. A busy input freezes that stepping. A static width input picks one of two output formats: one bit per clock, taken from each byte starting with its most significant bit, or one whole byte per clock.

When the pointer passes the last stored unit, the data outputs are released and an active-low cascade select output is pulled low. That output hands the stream over to the next memory in a chain. A single shared pin acts as both reset and output enable, and a polarity input decides which level of that pin means reset. Tri-state behaviour is modelled with a per-bit drive-enable vector that sits beside the data bus.

Top module: `cfg_prom_reader`

## Requirements
- R1: The read pointer advances by one on a rising clock edge only when chip select (`sel_n`) is low, output enable is active, `hold` is low, and the pointer has not yet passed the terminal count.
- R2: While `hold` is high, clock edges leave the pointer unchanged, and the data outputs keep showing the same value.
- R3: The drive-enable vector `dq_en` is nonzero only when `sel_n` is low, output enable is active, and the pointer is at or below the terminal count. In every other case it is all zero.
- R4: `next_sel_n` is low when `sel_n` is low, output enable is active, and the pointer is past the terminal count.
- R5: `next_sel_n` goes high in the same cycle that output enable goes inactive or `sel_n` goes high.
- R6: While reset is active, the pointer is cleared to zero on each clock edge and `dq_en` is zero.
- R7: While `sel_n` is high, the pointer is cleared to zero on each clock edge and `dq_en` is zero.
- R8: With `pol_lo_rst` = 0, a high level on `rst_oe` means reset and a low level means output enable. With `pol_lo_rst` = 1, the meanings are swapped.
- R9: With `wide` = 1 (byte mode), `dq_en` = 8'hFF and `dq` carries the byte at the pointer. With `wide` = 0 (bit mode), `dq_en` = 8'h01 and `dq[0]` carries bit (7 - p mod 8) of byte p/8, where p is the pointer.
- R10: The terminal count is `LAST_BYTE` in byte mode and `LAST_BYTE*8+7` in bit mode. Once the pointer passes it, the pointer stays at terminal count plus one.
- R11: A write strobe `wr_en` stores `wr_data` at `wr_addr` only while `sel_n` is high. Strobes issued while `sel_n` is low leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; the pointer steps on its rising edge |
| rst_oe | input | 1 | Shared reset / output-enable pin |
| pol_lo_rst | input | 1 | Polarity of `rst_oe`: 1 makes a low level mean reset |
| sel_n | input | 1 | Active-low chip select |
| hold | input | 1 | Busy input; freezes the pointer when high |
| wide | input | 1 | Output width: 1 = byte, 0 = bit |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write byte address |
| wr_data | input | 8 | Array write data |
| dq | output | 8 | Read data |
| dq_en | output | 8 | Per-bit drive enable; 0 means high impedance |
| next_sel_n | output | 1 | Active-low select for the next memory in the chain |

## Verification
A pointer that is off by one shows up on the very next sample as the byte or bit of a neighbouring position. A pointer that runs past the terminal count, or stops short of it, shows up within one cycle of the expected end: `dq_en` drops too early or too late, and `next_sel_n` goes low at the wrong time. A lost busy freeze or a missed clear after deselect puts a different data value on the pins at the next sample. A reversed bit order inside a byte corrupts the first serial bit that differs from its mirror image.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic {
        WIDTH_BIT  = 1'b0,
        WIDTH_BYTE = 1'b1
    } out_width_e;

    // Reset level decode of the shared pin
    function automatic logic rst_level(input logic pin, input logic pol_lo);
        return pol_lo ? ~pin : pin;
    endfunction

endpackage

// File: rtl/prom_array.sv
module prom_array #(
    parameter int BYTES = 64,
    parameter int AW    = 6,
    parameter int RW    = 10
) (
    input  logic          clk,
    input  logic          wr_open,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [RW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam logic [AW:0]   WR_LIMIT = (AW+1)'(BYTES);
    localparam logic [RW-1:0] RD_LIMIT = RW'(BYTES);

    logic [7:0] mem_q [BYTES];
    logic       wr_go;

    always_comb begin
        wr_go = wr_en & wr_open & ({1'b0, wr_addr} < WR_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr < RD_LIMIT) begin
            rd_data = mem_q[rd_addr[AW-1:0]];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/prom_addr_ctr.sv
module prom_addr_ctr #(
    parameter int CNT_W     = 10,
    parameter int LAST_BYTE = 63
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             hold,
    input  logic             wide,
    output logic [CNT_W-1:0] cnt_q,
    output logic             past_end
);
    import prom_pkg::*;

    localparam logic [CNT_W-1:0] TC_BYTE = CNT_W'(LAST_BYTE);
    localparam logic [CNT_W-1:0] TC_BIT  = CNT_W'(LAST_BYTE * 8 + 7);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [CNT_W-1:0] tc_sel;

    always_comb begin
        tc_sel   = (out_width_e'(wide) == WIDTH_BYTE) ? TC_BYTE : TC_BIT;
        past_end = st_q.cnt > tc_sel;
        st_d     = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (!hold && !past_end) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage (
    input  logic       wide,
    input  logic       active,
    input  logic       past_end,
    input  logic [2:0] bit_sel,
    input  logic [7:0] rd_byte,
    output logic [7:0] dq,
    output logic [7:0] dq_en,
    output logic       next_sel_n
);
    import prom_pkg::*;

    logic drive;

    always_comb begin
        drive      = active & ~past_end;
        next_sel_n = ~(active & past_end);
        dq         = '0;
        dq_en      = '0;
        if (drive) begin
            if (out_width_e'(wide) == WIDTH_BYTE) begin
                dq    = rd_byte;
                dq_en = 8'hFF;
            end else begin
                dq[0]    = rd_byte[3'd7 - bit_sel];
                dq_en[0] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader #(
    parameter int BYTES     = 64,
    parameter int LAST_BYTE = BYTES - 1,
    parameter int AW        = $clog2(BYTES),
    parameter int CNT_W     = $clog2(8 * BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_oe,
    input  logic          pol_lo_rst,
    input  logic          sel_n,
    input  logic          hold,
    input  logic          wide,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    dq,
    output logic [7:0]    dq_en,
    output logic          next_sel_n
);
    import prom_pkg::*;

    logic             rst_act;
    logic             clear;
    logic             active;
    logic [CNT_W-1:0] cnt_q;
    logic             past_end;
    logic [CNT_W-1:0] byte_idx;
    logic [7:0]       rd_byte;

    always_comb begin
        rst_act  = rst_level(rst_oe, pol_lo_rst);
        clear    = rst_act | sel_n;
        active   = ~clear;
        byte_idx = (out_width_e'(wide) == WIDTH_BYTE) ? cnt_q : (cnt_q >> 3);
    end

    prom_addr_ctr #(
        .CNT_W     (CNT_W),
        .LAST_BYTE (LAST_BYTE)
    ) u_ctr (
        .clk      (clk),
        .clear    (clear),
        .hold     (hold),
        .wide     (wide),
        .cnt_q    (cnt_q),
        .past_end (past_end)
    );

    prom_array #(
        .BYTES (BYTES),
        .AW    (AW),
        .RW    (CNT_W)
    ) u_mem (
        .clk     (clk),
        .wr_open (sel_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (byte_idx),
        .rd_data (rd_byte)
    );

    prom_out_stage u_out (
        .wide       (wide),
        .active     (active),
        .past_end   (past_end),
        .bit_sel    (cnt_q[2:0]),
        .rd_byte    (rd_byte),
        .dq         (dq),
        .dq_en      (dq_en),
        .next_sel_n (next_sel_n)
    );

endmodule

// File: rtl/prom_reader_chk.sv
module prom_reader_chk #(
    parameter int CNT_W     = 10,
    parameter int LAST_BYTE = 63
) (
    input logic             clk,
    input logic             rst_oe,
    input logic             pol_lo_rst,
    input logic             sel_n,
    input logic             hold,
    input logic             wide,
    input logic [7:0]       dq_en,
    input logic             next_sel_n,
    input logic [CNT_W-1:0] cnt_q
);

    logic             rst_c;
    logic [CNT_W-1:0] tc_c;

    always_comb begin
        rst_c = pol_lo_rst ? ~rst_oe : rst_oe;
        tc_c  = wide ? CNT_W'(LAST_BYTE) : CNT_W'(LAST_BYTE * 8 + 7);
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (rst_c)
        (!sel_n && !hold && cnt_q <= tc_c) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_freeze_R2: assert property (@(posedge clk) disable iff (rst_c)
        (!sel_n && hold) |=> $stable(cnt_q));

    assert_drive_R3: assert property (@(posedge clk) disable iff (rst_c)
        (dq_en != 8'h00) |-> (!sel_n && cnt_q <= tc_c));

    assert_cascade_low_R4: assert property (@(posedge clk) disable iff (rst_c)
        (!sel_n && cnt_q > tc_c) |-> !next_sel_n);

    assert_cascade_high_R5: assert property (@(posedge clk)
        (sel_n || rst_c) |-> next_sel_n);

    assert_reset_clear_R6: assert property (@(posedge clk)
        rst_c |=> (cnt_q == '0));

    assert_desel_clear_R7: assert property (@(posedge clk) disable iff (rst_c)
        sel_n |=> (cnt_q == '0));

    assert_bit_lanes_R9: assert property (@(posedge clk) disable iff (rst_c)
        !wide |-> (dq_en[7:1] == 7'd0));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst_c)
        cnt_q <= tc_c + 1'b1);

endmodule

bind cfg_prom_reader prom_reader_chk #(
    .CNT_W     (CNT_W),
    .LAST_BYTE (LAST_BYTE)
) u_chk (
    .clk        (clk),
    .rst_oe     (rst_oe),
    .pol_lo_rst (pol_lo_rst),
    .sel_n      (sel_n),
    .hold       (hold),
    .wide       (wide),
    .dq_en      (dq_en),
    .next_sel_n (next_sel_n),
    .cnt_q      (cnt_q)
);

// File: tb/tb_cfg_prom_reader.sv
module tb_cfg_prom_reader;

    localparam int CLK_PERIOD = 10;
    localparam int BYTES      = 8;
    localparam int LAST_BYTE  = 5;
    localparam int AW         = $clog2(BYTES);
    localparam int CNT_W      = $clog2(8 * BYTES + 1);

    logic          clk = 1'b0;
    logic          rst_oe = 1'b1;
    logic          pol_lo_rst = 1'b0;
    logic          sel_n = 1'b1;
    logic          hold = 1'b0;
    logic          wide = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    dq;
    logic [7:0]    dq_en;
    logic          next_sel_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_prom_reader #(
        .BYTES     (BYTES),
        .LAST_BYTE (LAST_BYTE)
    ) dut (
        .clk        (clk),
        .rst_oe     (rst_oe),
        .pol_lo_rst (pol_lo_rst),
        .sel_n      (sel_n),
        .hold       (hold),
        .wide       (wide),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dq         (dq),
        .dq_en      (dq_en),
        .next_sel_n (next_sel_n)
    );

    function automatic logic [7:0] img(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

    initial begin
        // fill the array while deselected
        for (int i = 0; i < BYTES; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = img(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        // R11: strobe while selected must be ignored
        sel_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(1); wr_data = ~img(1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6 reset dq_en", 32'(dq_en), 32'h0);
        check("R5 reset next_sel_n", 32'(next_sel_n), 32'h1);

        // byte mode sweep, active-high reset polarity (R8)
        @(negedge clk);
        rst_oe = 1'b0;
        #1;
        for (int i = 0; i <= LAST_BYTE; i++) begin
            check("R9 byte dq_en", 32'(dq_en), 32'hFF);
            check(i == 1 ? "R11 byte kept" : "R1 byte data", 32'(dq), 32'(img(i)));
            check("R4 cascade high while reading", 32'(next_sel_n), 32'h1);
            @(negedge clk);
        end
        check("R3 tristate at end", 32'(dq_en), 32'h0);
        check("R4 cascade low at end", 32'(next_sel_n), 32'h0);
        repeat (3) @(negedge clk);
        check("R10 stays past end", 32'(dq_en), 32'h0);
        check("R10 cascade stays low", 32'(next_sel_n), 32'h0);
        rst_oe = 1'b1;
        #1;
        check("R5 cascade high on oe off", 32'(next_sel_n), 32'h1);
        check("R6 tristate in reset", 32'(dq_en), 32'h0);
        @(negedge clk);
        rst_oe = 1'b0;
        #1;
        check("R6 pointer cleared", 32'(dq), 32'(img(0)));

        // exhaust again, then deselect
        repeat (LAST_BYTE + 1) @(negedge clk);
        check("R4 cascade low again", 32'(next_sel_n), 32'h0);
        sel_n = 1'b1;
        #1;
        check("R5 cascade high on deselect", 32'(next_sel_n), 32'h1);
        check("R7 tristate deselected", 32'(dq_en), 32'h0);
        @(negedge clk);
        sel_n = 1'b0;
        #1;
        check("R7 pointer cleared", 32'(dq), 32'(img(0)));

        // busy freeze
        repeat (2) @(negedge clk);
        check("R1 advance to 2", 32'(dq), 32'(img(2)));
        hold = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 frozen data", 32'(dq), 32'(img(2)));
        check("R2 still driven", 32'(dq_en), 32'hFF);
        hold = 1'b0;
        @(negedge clk);
        check("R1 resume", 32'(dq), 32'(img(3)));

        // bit mode, active-low reset polarity
        pol_lo_rst = 1'b1; rst_oe = 1'b0; wide = 1'b0;
        @(negedge clk);
        check("R8 low level resets", 32'(dq_en), 32'h0);
        rst_oe = 1'b1;
        #1;
        for (int k = 0; k < (LAST_BYTE + 1) * 8; k++) begin
            check("R9 bit dq_en", 32'(dq_en), 32'h01);
            check("R9 bit order", 32'(dq[0]), 32'(img(k / 8) >> (7 - (k % 8))) & 32'h1);
            @(negedge clk);
        end
        check("R10 bit mode end", 32'(dq_en), 32'h0);
        check("R4 bit mode cascade", 32'(next_sel_n), 32'h0);
        rst_oe = 1'b0;
        #1;
        check("R8 low level releases cascade", 32'(next_sel_n), 32'h1);

        done = 1'b1;
        finish_run();
    end

endmodule